// File: doc/BRIEF.md
# PHY Reset and Power-Down Controller

This block sequences reset and low-power entry for the management register set of a 10/100 Ethernet transceiver. It merges an active-low power-on reset and an active-low hardware reset pin into a single reset. The two reset inputs take effect immediately and are released through a synchroniser on the reference clock. It also watches management writes to the reset bit (bit 15) and the power-down bit (bit 11) of the basic control word.

From these inputs it drives three kinds of output. The first is a set of reinitialise strobes, one per register class, for the register file. The second is a load strobe together with the latched strapped PHY address. The third is the enables that force the MAC-side outputs to zero and tri-state the twisted-pair transmitter while the part is powered down.

The three entry paths behave differently. A software reset clears itself after a fixed hold time, does not power the part down, and leaves the latched address untouched. A register power-down keeps the register contents except for the latching status classes. A pin reset or power-on reset powers the part down, reloads every class on release, and latches the strap pins again.

Top module: `phy_rpd_ctrl`

## Requirements
- R1: A management write with the reset bit set (and no pin or power-on reset active) holds `ctrl_rst_bit_o` and `in_reset_o` high for exactly two reference-clock cycles, starting with the cycle after the write edge.
- R2: When a software reset ends, `ctrl_rst_bit_o` reads 0. In the same cycle `reinit_o` is 4'b1111 for one cycle, and `ctrl_pd_bit_o` reads 0. The class bits of `reinit_o` are: bit 0 general configuration, bit 1 latching-low status, bit 2 latching-high status, bit 3 latching-maximum status.
- R3: A new write with the reset bit set during a running software reset restarts the two-cycle hold from that write. A write with the reset bit clear during a software reset is ignored.
- R4: During a software reset `pwr_down_o`, `mac_zero_o` and `tp_tristate_o` stay 0. `addr_load_o` stays 0 and `phy_addr_o` keeps its value.
- R5: While `rst_ni` or `hw_rst_ni` is low, `in_reset_o`, `pwr_down_o`, `mac_zero_o` and `tp_tristate_o` are 1. They assert without waiting for a clock edge.
- R6: After the last reset input rises, `in_reset_o` and `pwr_down_o` fall on the second rising edge. On the third edge `reinit_o` becomes 4'b1111 and `addr_load_o` becomes 1 for one cycle, and `phy_addr_o` takes the value on `strap_addr_i`. `phy_addr_o` changes at no other time.
- R7: A write with the reset bit clear and the power-down bit set raises `pwr_down_o`, `mac_zero_o` and `tp_tristate_o` from the next edge. On entry only, `reinit_o` is 4'b1110 for one cycle. A repeated write while already powered down gives no strobe.
- R8: A write with both bits clear releases `pwr_down_o`, `mac_zero_o` and `tp_tristate_o` on the next edge, with `reinit_o` at 0.
- R9: A pin or power-on reset never sets `ctrl_rst_bit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| hw_rst_ni | input | 1 | Hardware reset pin, active low, asynchronous assert |
| ctrl_wr_i | input | 1 | Management write to the control word, one cycle |
| ctrl_wdata_rst_i | input | 1 | Bit 15 (reset) of the written control word |
| ctrl_wdata_pd_i | input | 1 | Bit 11 (power-down) of the written control word |
| strap_addr_i | input | ADDR_W | Strapped PHY address pins |
| reinit_o | output | 4 | Per-class reinitialise strobes |
| addr_load_o | output | 1 | Pulses in the cycle a new address appears on phy_addr_o |
| phy_addr_o | output | ADDR_W | Latched PHY address |
| ctrl_rst_bit_o | output | 1 | Read-back of control bit 15 |
| ctrl_pd_bit_o | output | 1 | Read-back of control bit 11 |
| in_reset_o | output | 1 | Block is in a reset state |
| pwr_down_o | output | 1 | Power-down indication |
| mac_zero_o | output | 1 | Force MAC-side outputs to zero |
| tp_tristate_o | output | 1 | Tri-state the twisted-pair transmitter |

## Verification
The assertions are switched off whenever either reset input is low. They assume that management writes are single-cycle pulses on the reference clock, and that the strap pins are quiet around the address load edge. The stimulus changes every input on the falling clock edge. It holds the strap pins steady through each reset release, and it changes reset inputs away from rising edges. Random write traffic runs only while both resets are high, so the properties about software reset and power-down see the full sequences they describe.

// File: rtl/phy_rpd_pkg.sv
package phy_rpd_pkg;
  typedef enum logic [1:0] {
    CLS_CFG = 2'd0,
    CLS_LL  = 2'd1,
    CLS_LH  = 2'd2,
    CLS_LMX = 2'd3
  } reg_cls_e;

  localparam int NUM_CLS = 4;
  localparam logic [NUM_CLS-1:0] MASK_ALL   = '1;
  localparam logic [NUM_CLS-1:0] MASK_LATCH = MASK_ALL & ~(NUM_CLS'(1) << CLS_CFG);
endpackage

// File: rtl/phy_rpd_sync.sv
module phy_rpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rel_o
);
  logic [STAGES-1:0] sync_q;

  // assert asynchronously, release through STAGES flops
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rel_o = sync_q[STAGES-1];
endmodule

// File: rtl/phy_rpd_swrst.sv
module phy_rpd_swrst #(
  parameter int HOLD = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int            CW   = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q & ~start_i & (cnt_q == LAST);
endmodule

// File: rtl/phy_rpd_ctrl.sv
module phy_rpd_ctrl
  import phy_rpd_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SRST_HOLD   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hw_rst_ni,
  input  logic               ctrl_wr_i,
  input  logic               ctrl_wdata_rst_i,
  input  logic               ctrl_wdata_pd_i,
  input  logic [ADDR_W-1:0]  strap_addr_i,
  output logic [NUM_CLS-1:0] reinit_o,
  output logic               addr_load_o,
  output logic [ADDR_W-1:0]  phy_addr_o,
  output logic               ctrl_rst_bit_o,
  output logic               ctrl_pd_bit_o,
  output logic               in_reset_o,
  output logic               pwr_down_o,
  output logic               mac_zero_o,
  output logic               tp_tristate_o
);
  logic arst_n;
  logic hw_rel, hw_rel_q;
  logic run, hard_end;
  logic sw_start, sw_busy, sw_done;
  logic pd_q, pd_d, pd_evt, full_evt;
  logic [NUM_CLS-1:0] reinit_d, reinit_q;
  logic               addr_load_q;
  logic [ADDR_W-1:0]  phy_addr_q;

  assign arst_n = rst_ni & hw_rst_ni;

  phy_rpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .arst_ni (arst_n),
    .rel_o   (hw_rel)
  );

  // run: released and past the hard-reset exit cycle
  assign run      = hw_rel & hw_rel_q;
  assign hard_end = hw_rel & ~hw_rel_q;
  assign sw_start = run & ctrl_wr_i & ctrl_wdata_rst_i;

  phy_rpd_swrst #(.HOLD(SRST_HOLD)) u_swrst (
    .clk_i   (clk_i),
    .arst_ni (arst_n),
    .start_i (sw_start),
    .busy_o  (sw_busy),
    .done_o  (sw_done)
  );

  assign pd_evt   = run & ~sw_busy & ~sw_start & ctrl_wr_i & ctrl_wdata_pd_i & ~pd_q;
  assign full_evt = hard_end | sw_done;

  always_comb begin
    pd_d = pd_q;
    if (!run || sw_start || sw_busy) pd_d = 1'b0;
    else if (ctrl_wr_i)              pd_d = ctrl_wdata_pd_i;
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    if (MASK_LATCH[c]) begin : g_latch
      assign reinit_d[c] = full_evt | pd_evt;
    end else begin : g_keep
      assign reinit_d[c] = full_evt;
    end
  end

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) begin
      hw_rel_q    <= 1'b0;
      pd_q        <= 1'b0;
      reinit_q    <= '0;
      addr_load_q <= 1'b0;
      phy_addr_q  <= '0;
    end else begin
      hw_rel_q    <= hw_rel;
      pd_q        <= pd_d;
      reinit_q    <= reinit_d;
      addr_load_q <= hard_end;
      if (hard_end) phy_addr_q <= strap_addr_i;
    end
  end

  assign reinit_o       = reinit_q;
  assign addr_load_o    = addr_load_q;
  assign phy_addr_o     = phy_addr_q;
  assign ctrl_rst_bit_o = sw_busy;
  assign ctrl_pd_bit_o  = pd_q;
  assign in_reset_o     = ~hw_rel | sw_busy;
  assign pwr_down_o     = ~hw_rel | pd_q;
  assign mac_zero_o     = pwr_down_o;
  assign tp_tristate_o  = pwr_down_o;
endmodule

// File: rtl/phy_rpd_chk.sv
module phy_rpd_chk
  import phy_rpd_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               hw_rst_ni,
  input logic [NUM_CLS-1:0] reinit_o,
  input logic               addr_load_o,
  input logic [ADDR_W-1:0]  phy_addr_o,
  input logic               ctrl_rst_bit_o,
  input logic               ctrl_pd_bit_o,
  input logic               pwr_down_o
);
  AST_SWRST_MIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !hw_rst_ni)
    $rose(ctrl_rst_bit_o) |=> ctrl_rst_bit_o); // R1

  AST_SWRST_EXIT_REINIT: assert property (@(posedge clk_i) disable iff (!rst_ni || !hw_rst_ni)
    $fell(ctrl_rst_bit_o) |-> (reinit_o == MASK_ALL && !ctrl_pd_bit_o)); // R2

  AST_SWRST_NO_PWRDN: assert property (@(posedge clk_i) disable iff (!rst_ni || !hw_rst_ni)
    ctrl_rst_bit_o |-> !pwr_down_o); // R4

  AST_SWRST_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni || !hw_rst_ni)
    ctrl_rst_bit_o |-> !addr_load_o); // R4

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni || !hw_rst_ni)
    !addr_load_o |-> $stable(phy_addr_o)); // R6

  AST_PD_ENTRY_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni || !hw_rst_ni)
    $rose(ctrl_pd_bit_o) |-> reinit_o == MASK_LATCH); // R7

  AST_PD_BIT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni || !hw_rst_ni)
    ctrl_pd_bit_o |-> pwr_down_o); // R7

  AST_PD_EXIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni || !hw_rst_ni)
    $fell(ctrl_pd_bit_o) |-> reinit_o == '0); // R8
endmodule

bind phy_rpd_ctrl phy_rpd_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/phy_rpd_ctrl_bench.sv
module phy_rpd_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_rst_n = 1'b1;
  logic       wr = 1'b0, wd_rst = 1'b0, wd_pd = 1'b0;
  logic [4:0] strap = 5'h00;
  logic [3:0] reinit;
  logic       addr_load, rst_bit, pd_bit, in_reset, pwr_down, mac_zero, tp_tri;
  logic [4:0] phy_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  phy_rpd_ctrl u_phy_rpd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hw_rst_ni(hw_rst_n),
    .ctrl_wr_i(wr), .ctrl_wdata_rst_i(wd_rst), .ctrl_wdata_pd_i(wd_pd),
    .strap_addr_i(strap), .reinit_o(reinit), .addr_load_o(addr_load),
    .phy_addr_o(phy_addr), .ctrl_rst_bit_o(rst_bit), .ctrl_pd_bit_o(pd_bit),
    .in_reset_o(in_reset), .pwr_down_o(pwr_down), .mac_zero_o(mac_zero),
    .tp_tristate_o(tp_tri)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_entry_mask(input logic was_pd, input logic new_pd);
    return (new_pd && !was_pd) ? 4'b1110 : 4'b0000;
  endfunction

  task automatic write(input logic r, input logic p);
    wr = 1'b1; wd_rst = r; wd_pd = p;
    @(negedge clk);
    wr = 1'b0; wd_rst = 1'b0; wd_pd = 1'b0;
  endtask

  task automatic release_seq(input logic [4:0] s, input bit por);
    strap = s;
    if (por) rst_n = 1'b1; else hw_rst_n = 1'b1;
    @(negedge clk);
    check("R6 still in reset after first edge", in_reset, 1);
    @(negedge clk);
    check("R6 in_reset drops on second edge", in_reset, 0);
    check("R6 pwr_down drops on second edge", pwr_down, 0);
    check("R6 no load yet", addr_load, 0);
    @(negedge clk);
    check("R6 address load strobe", addr_load, 1);
    check("R6 full reinit on release", reinit, 4'hF);
    check("R6 address latched", phy_addr, s);
    check("R9 reset bit never set by pin", rst_bit, 0);
    @(negedge clk);
    check("R6 load strobe single cycle", addr_load, 0);
    check("R6 reinit single cycle", reinit, 0);
  endtask

  task automatic random_phase(input int n);
    logic m_pd = 1'b0, m_busy = 1'b0;
    int   m_cnt = 0;
    for (int i = 0; i < n; i++) begin
      logic w, r, p;
      logic [3:0] e_re;
      w = ($urandom % 3) == 0;
      r = ($urandom % 6) == 0;
      p = $urandom % 2;
      wr = w; wd_rst = r; wd_pd = p;
      e_re = 4'h0;
      if (w && r) begin
        m_busy = 1'b1; m_cnt = 0; m_pd = 1'b0;
      end else if (m_busy) begin
        if (m_cnt == 1) begin m_busy = 1'b0; m_cnt = 0; e_re = 4'hF; m_pd = 1'b0; end
        else m_cnt++;
      end else if (w) begin
        e_re = exp_entry_mask(m_pd, p);
        m_pd = p;
      end
      @(negedge clk);
      check("R1/R3 random reset bit", rst_bit, m_busy);
      check("R1 random in_reset", in_reset, m_busy);
      check("R7/R8 random pwr_down", pwr_down, m_pd);
      check("R2/R7 random reinit", reinit, e_re);
    end
    wr = 1'b0; wd_rst = 1'b0; wd_pd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    check("R5 power-on in_reset", in_reset, 1);
    check("R5 power-on pwr_down", pwr_down, 1);
    check("R5 power-on mac_zero", mac_zero, 1);
    check("R5 power-on tristate", tp_tri, 1);
    check("R9 power-on reset bit", rst_bit, 0);
    release_seq(5'h13, 1'b1);

    // register power-down entry and exit
    write(1'b0, 1'b1);
    check("R7 pwr_down set", pwr_down, 1);
    check("R7 mac_zero set", mac_zero, 1);
    check("R7 tristate set", tp_tri, 1);
    check("R7 latching classes strobed", reinit, 4'b1110);
    @(negedge clk);
    check("R7 strobe single cycle", reinit, 0);
    write(1'b0, 1'b1);
    check("R7 no strobe when already down", reinit, 0);
    write(1'b0, 1'b0);
    check("R8 pwr_down released", pwr_down, 0);
    check("R8 mac_zero released", mac_zero, 0);
    check("R8 tristate released", tp_tri, 0);
    check("R8 no reinit on exit", reinit, 0);

    // software reset out of power-down
    write(1'b0, 1'b1);
    strap = 5'h0A;
    write(1'b1, 1'b0);
    check("R1 reset bit cycle 1", rst_bit, 1);
    check("R1 in_reset cycle 1", in_reset, 1);
    check("R4 no power-down in soft reset", pwr_down, 0);
    check("R4 no mac zero in soft reset", mac_zero, 0);
    @(negedge clk);
    check("R1 reset bit cycle 2", rst_bit, 1);
    check("R4 no load in soft reset", addr_load, 0);
    @(negedge clk);
    check("R2 reset bit self-clears", rst_bit, 0);
    check("R2 full reinit at end", reinit, 4'hF);
    check("R2 pd bit default", pd_bit, 0);
    check("R4 address kept", phy_addr, 5'h13);
    @(negedge clk);

    // restart and ignored write during soft reset
    write(1'b1, 1'b0);
    write(1'b1, 1'b0);
    check("R3 restarted", rst_bit, 1);
    wr = 1'b1; wd_pd = 1'b1;
    @(negedge clk);
    wr = 1'b0; wd_pd = 1'b0;
    check("R3 still in reset after restart", rst_bit, 1);
    check("R3 pd write ignored", pwr_down, 0);
    @(negedge clk);
    check("R3 ends two cycles after restart", rst_bit, 0);
    check("R3 pd bit still clear", pd_bit, 0);

    // asynchronous pin reset
    #2 hw_rst_n = 1'b0;
    #1;
    check("R5 pin pwr_down immediate", pwr_down, 1);
    check("R5 pin in_reset immediate", in_reset, 1);
    check("R5 pin tristate immediate", tp_tri, 1);
    @(negedge clk);
    check("R9 pin reset bit", rst_bit, 0);
    release_seq(5'h0A, 1'b0);

    random_phase(400);
    check("R6 address unchanged after random traffic", phy_addr, 5'h0A);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule